// File: doc/BRIEF.md
# Multi-context pipeline register bank

This block sits between two pipeline stages and holds one saved copy of the stage payload (a data word and its valid bit) for each of N hardware threads. One thread is active at a time. Its copy acts as the live pipeline register. It is loaded from upstream and shown downstream exactly like an ordinary clocked register.

When a switch command names another thread, the live copy stays in the outgoing thread's slot rather than being flushed. The active select then moves to the incoming thread. The bank stalls upstream and hides its output for a programmable read delay of 1 to 3 cycles, and then presents the incoming thread's saved payload. A separate background port lets a finished long-latency result land in any thread's slot, including the active one, without disturbing the others.

Top module: `ctx_pipe_reg`

## Requirements
- R1: While `rst_n` is low and on the first cycle after release, all slots are zero, `active_tid` is 0, `stall_up` is 0 and `dn_valid` is 0.
- R2: With no switch in progress, no switch accepted and no background write to the active thread, the next cycle's `dn_data`/`dn_valid` equal this cycle's `up_data`/`up_valid`.
- R3: A switch is accepted when `sw_req` is high, no switch is in progress and `sw_tid` differs from `active_tid`. From the following cycle `stall_up` is 1 and `dn_valid` is 0 for the whole switch delay, and upstream is not loaded.
- R4: The switch delay in cycles equals `sw_lat` sampled at acceptance for values 1, 2 and 3; a value of 0 gives 1 cycle.
- R5: At the accepting edge, the outgoing thread's slot takes that cycle's upstream payload. Its contents are then kept, so a later switch back presents them unchanged.
- R6: A switch request naming the active thread does nothing: no stall, no change of `active_tid`, and normal loading continues.
- R7: `sw_req` while a switch is in progress is ignored.
- R8: A background write (`bg_we`) stores `bg_data` into slot `bg_tid` and marks it valid; the value appears downstream once that thread becomes active.
- R9: A background write to the active thread updates the live register and takes priority over the upstream load in the same cycle.
- R10: Slots of inactive threads that receive no background write keep their contents.
- R11: `active_tid` takes the value of `sw_tid` on the cycle after an accepted switch. When the delay ends, `dn_valid` shows the incoming slot's valid bit together with its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream payload valid |
| up_data | input | W | Upstream payload |
| stall_up | output | 1 | Upstream must hold: switch in progress |
| dn_valid | output | 1 | Downstream payload valid |
| dn_data | output | W | Downstream payload (live slot) |
| sw_req | input | 1 | Thread switch request |
| sw_tid | input | log2(N) | Thread to switch to |
| sw_lat | input | 2 | Switch read delay, 1..3 (0 means 1) |
| bg_we | input | 1 | Background result write |
| bg_tid | input | log2(N) | Thread slot for the background write |
| bg_data | input | W | Background result value |
| active_tid | output | log2(N) | Currently active thread |

## Verification
The embedded assertions check four things on every cycle: register-like pass-through outside a switch, the start of a stall with the new thread selected after an accepted request, the hidden output throughout a stall, and that requests arriving mid-switch or naming the active thread change nothing. Other behaviour shows up only over longer scenarios, which the bench drives: the exact length of each delay setting, saved slots surviving several switches, background results appearing only when their thread is selected, and background writes overriding upstream loads.

// File: rtl/ctx_pipe_reg.sv
module ctx_pipe_reg #(
  parameter int N = 4,
  parameter int W = 16,
  localparam int TW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  input  logic [W-1:0]  up_data,
  output logic          stall_up,
  output logic          dn_valid,
  output logic [W-1:0]  dn_data,
  input  logic          sw_req,
  input  logic [TW-1:0] sw_tid,
  input  logic [1:0]    sw_lat,
  input  logic          bg_we,
  input  logic [TW-1:0] bg_tid,
  input  logic [W-1:0]  bg_data,
  output logic [TW-1:0] active_tid
);

  logic [W-1:0]  slot [N];
  logic [N-1:0]  slot_v;
  logic [TW-1:0] act;
  logic [1:0]    cnt;
  logic          busy, take;

  assign busy       = (cnt != 2'd0);
  assign take       = sw_req && !busy && (sw_tid != act);
  assign stall_up   = busy;
  assign dn_valid   = slot_v[act] && !busy;
  assign dn_data    = slot[act];
  assign active_tid = act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < N; t++) slot[t] <= '0;
      slot_v <= '0;
      act    <= '0;
      cnt    <= '0;
    end else begin
      for (int t = 0; t < N; t++) begin
        if (bg_we && bg_tid == TW'(t)) begin
          slot[t]   <= bg_data;
          slot_v[t] <= 1'b1;
        end else if (!busy && act == TW'(t)) begin
          slot[t]   <= up_data;
          slot_v[t] <= up_valid;
        end
      end
      if (take) begin
        act <= sw_tid;
        cnt <= (sw_lat == 2'd0) ? 2'd1 : sw_lat;
      end else if (busy) begin
        cnt <= cnt - 2'd1;
      end
    end
  end

  // R2: ordinary register behaviour outside a switch
  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_up && !(sw_req && sw_tid != active_tid) && !(bg_we && bg_tid == active_tid))
    |=> (dn_valid == $past(up_valid) && dn_data == $past(up_data)));

  // R3 / R11: accepted switch stalls and selects the new thread
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_up && sw_req && sw_tid != active_tid)
    |=> (stall_up && active_tid == $past(sw_tid)));

  // R3: output hidden during the switch delay
  p_hide_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_up |-> !dn_valid);

  // R6: request for the active thread is a no-op
  p_noop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_up && sw_req && sw_tid == active_tid)
    |=> (!stall_up && $stable(active_tid)));

  // R7: requests during a switch are ignored
  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_up |=> $stable(active_tid));

endmodule

// File: tb/test_ctx_pipe_reg.sv
module test_ctx_pipe_reg;
  localparam int N = 4;
  localparam int W = 16;
  localparam int TW = 2;

  logic clk = 0, rst_n = 0;
  logic up_valid = 0, sw_req = 0, bg_we = 0;
  logic [W-1:0] up_data = '0, bg_data = '0;
  logic [TW-1:0] sw_tid = '0, bg_tid = '0;
  logic [1:0] sw_lat = '0;
  logic stall_up, dn_valid;
  logic [W-1:0] dn_data;
  logic [TW-1:0] active_tid;

  int compared = 0, mismatched = 0;

  logic [W-1:0] m_d [N];
  logic [N-1:0] m_v;
  logic [TW-1:0] m_act;
  int m_cnt;

  always #5 clk = ~clk;

  ctx_pipe_reg #(.N(N), .W(W)) i_ctx_pipe_reg (
    .clk, .rst_n, .up_valid, .up_data, .stall_up, .dn_valid, .dn_data,
    .sw_req, .sw_tid, .sw_lat, .bg_we, .bg_tid, .bg_data, .active_tid);

  function automatic int lat_of(input logic [1:0] l);
    return (l == 2'd0) ? 1 : int'(l);
  endfunction

  task automatic chk(input string tag, input string what, input int a, input int e);
    compared++;
    if (a != e) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, a, e);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "stall_up", int'(stall_up), int'(m_cnt != 0));
    chk(tag, "dn_valid", int'(dn_valid), int'(m_v[m_act] && m_cnt == 0));
    chk(tag, "dn_data", int'(dn_data), int'(m_d[m_act]));
    chk(tag, "active_tid", int'(active_tid), int'(m_act));
  endtask

  task automatic model_step();
    logic tk;
    tk = sw_req && m_cnt == 0 && sw_tid != m_act;
    for (int t = 0; t < N; t++) begin
      if (bg_we && int'(bg_tid) == t) begin
        m_d[t] = bg_data; m_v[t] = 1'b1;
      end else if (m_cnt == 0 && int'(m_act) == t) begin
        m_d[t] = up_data; m_v[t] = up_valid;
      end
    end
    if (tk) begin
      m_act = sw_tid; m_cnt = lat_of(sw_lat);
    end else if (m_cnt != 0) m_cnt--;
  endtask

  task automatic cyc(input logic uv, input logic [W-1:0] ud, input logic sr,
                     input logic [TW-1:0] st, input logic [1:0] sl, input logic bw,
                     input logic [TW-1:0] bt, input logic [W-1:0] bd, input string tag);
    up_valid = uv; up_data = ud; sw_req = sr; sw_tid = st; sw_lat = sl;
    bg_we = bw; bg_tid = bt; bg_data = bd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk_all(tag);
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int t = 0; t < N; t++) m_d[t] = '0;
    m_v = '0; m_act = '0; m_cnt = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "stall_up", int'(stall_up), 0);
    chk("R1", "dn_valid", int'(dn_valid), 0);
    chk("R1", "dn_data", int'(dn_data), 0);
    chk("R1", "active_tid", int'(active_tid), 0);
    rst_n = 1;
    // R2: pass-through
    cyc(1, 16'h1111, 0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 16'h2222, 0, 0, 0, 0, 0, 0, "R2");
    cyc(1, 16'hA5A5, 0, 0, 0, 0, 0, 0, "R2");
    // R3 R4 R11: switch 0->1, delay 2; outgoing slot gets 0xBEEF (R5)
    cyc(1, 16'hBEEF, 1, 1, 2, 0, 0, 0, "R11");
    chk("R3", "stall first", int'(stall_up), 1);
    cyc(1, 16'hDEAD, 0, 0, 0, 0, 0, 0, "R4");
    cyc(1, 16'h0001, 0, 0, 0, 0, 0, 0, "R4");
    chk("R4", "stall released after 2", int'(stall_up), 0);
    // R6: switch to active is no-op
    cyc(1, 16'h3333, 1, 1, 3, 0, 0, 0, "R6");
    chk("R6", "no stall", int'(stall_up), 0);
    // R4: delay 0 means 1; back to thread 0 (R5)
    cyc(1, 16'h4444, 1, 0, 0, 0, 0, 0, "R4");
    // R7: request during stall ignored
    cyc(1, 16'h5555, 1, 2, 3, 0, 0, 0, "R7");
    chk("R5", "saved data of thread 0", int'(dn_data), 16'hBEEF);
    chk("R7", "active kept", int'(active_tid), 0);
    // R8: background write to inactive thread 2, then switch with delay 3
    cyc(1, 16'h6666, 0, 0, 0, 1, 2, 16'hCAFE, "R8");
    cyc(0, 16'h7777, 1, 2, 3, 0, 0, 0, "R4");
    repeat (3) cyc(0, 0, 0, 0, 0, 0, 0, 0, "R4");
    chk("R8", "bg data shown", int'(dn_data), 16'hCAFE);
    chk("R8", "bg valid shown", int'(dn_valid), 1);
    // R9: background write to active overrides upstream
    cyc(1, 16'h8888, 0, 0, 0, 1, 2, 16'h1234, "R9");
    chk("R9", "bg wins", int'(dn_data), 16'h1234);
    // R10: thread 3 never touched stays zero/invalid
    cyc(1, 16'h9999, 1, 3, 1, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    chk("R10", "untouched slot", int'(dn_data), 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      cyc($urandom_range(0, 1), W'($urandom), ($urandom_range(0, 3) == 0),
          TW'($urandom_range(0, N - 1)), 2'($urandom_range(0, 3)),
          ($urandom_range(0, 7) == 0), TW'($urandom_range(0, N - 1)), W'($urandom),
          "R2/R5/R10");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
  end
endmodule